// File: doc/BRIEF.md
# Square-Wave Clock Output Timer

This block is a 16-bit up-counting timer with automatic reload, used to put a square wave with an exact 50% duty cycle on an output pin. Software writes a reload value as two bytes and sets three control bits: a run bit, a counter/timer select bit and an output-enable bit. While the run bit is set and the select bit is clear, the counter steps once for each cycle in which the tick enable is high. The tick enable is meant to pulse at half the oscillator rate. When the counter passes its all-ones value it loads the reload value and the output level flips.

Each flip marks one half period. The pin therefore runs at the tick rate divided by 2 × (65536 − reload), which is the oscillator frequency divided by 4 × (65536 − reload). The high phase and the low phase are always the same length. A sticky flag records each wrap. The external count input, capture and interrupts are outside this block, so setting the select bit only stops the counter and parks the pin.

Top module: `clkout_timer`

## Requirements
- R1: After reset the control bits, flag, reload value and counter are all zero and the pin is 1. The first wrap comes 65536 ticks after the run bit is set.
- R2: The counter advances by exactly one on each clock edge at which run=1, select=0 and tick_i=1. A cycle with tick_i low delays the next flip by one cycle.
- R3: When the counter is all ones and advances, it loads the reload value on that same edge. Each half period is then 65536 − reload ticks.
- R4: With output enable=1 and select=0, the pin shows the toggle level, which starts at 1 and flips on every wrap. Otherwise the pin is 1.
- R5: With run=0 the counter and the pin hold their values. Setting run again resumes from where the counter stopped.
- R6: With select=1 the counter does not advance and the pin is 1. Clearing select brings back the held toggle level.
- R7: A reload write made while the timer runs does not change the current half period. It applies from the next wrap.
- R8: The flag goes to 1 on the edge after a wrap and stays at 1 until software writes 0 to control bit 3. On a wrap, setting the flag wins over a write in the same cycle.
- R9: Register map (write-only, wr_addr_i): address 0 is control, with bit 0 run, bit 1 select, bit 2 output enable and bit 3 flag. Address 1 is the reload low byte and address 2 is the reload high byte. Writes to address 3 have no effect.
- R10: For a fixed reload value, consecutive high and low pin phases have the same length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable derived from the oscillator |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| clk_pin_o | output | 1 | Square-wave output pin |
| ovf_flag_o | output | 1 | Sticky wrap flag |

## Verification
The assertions check, on every cycle, the rules for single steps: the counter steps by one, reloads from the register on a wrap, and freezes when stopped, when ticks are missing or when select is set. They also check that the pin only changes level after a wrap, that the flag is sticky, and that address 3 leaves the registers alone. The bench scenarios show the behaviour over whole periods: the exact half-period lengths and their equality, the 65536-tick first wrap after reset, a reload change taking effect one half period late, the lengths added by a pause or by missing ticks, and the pin parking high.

// File: rtl/clkout_pkg.sv
package clkout_pkg;
  localparam int ADDR_CTRL = 0;

  // control byte bits [3:0]: ovf, out_en, cnt_sel, run
  typedef struct packed {
    logic ovf;
    logic out_en;
    logic cnt_sel;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  localparam int NSEG  = CNT_W / REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              wrap_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  reload_o
);
  ctrl_t ctrl_q;
  logic  ctrl_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wrap_i)  ctrl_q.ovf <= 1'b1;  // hardware set wins
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic [REG_W-1:0] seg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seg_q <= '0;
      else if (wr_en_i && (wr_addr_i == ADDR_W'(i + 1))) seg_q <= wr_data_i;
    end
    assign reload_o[i*REG_W +: REG_W] = seg_q;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/clkout_counter.sv
module clkout_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cnt_sel_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] count_q;
  logic             inc;

  assign inc    = run_i && !cnt_sel_i && tick_i;
  assign wrap_o = inc && (&count_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (wrap_o) count_q <= reload_i;
    else if (inc)    count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/clkout_wave.sv
module clkout_wave (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wrap_i,
  input  logic out_en_i,
  input  logic cnt_sel_i,
  output logic pin_o
);
  logic tgl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tgl_q <= 1'b1;
    else if (wrap_i) tgl_q <= ~tgl_q;
  end

  // port latch default is high when clock-out is not selected
  assign pin_o = (out_en_i && !cnt_sel_i) ? tgl_q : 1'b1;
endmodule

// File: rtl/clkout_timer.sv
module clkout_timer
  import clkout_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic              clk_pin_o,
  output logic              ovf_flag_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             wrap;
  logic             run_w, sel_w, oe_w;

  assign run_w = ctrl.run;
  assign sel_w = ctrl.cnt_sel;
  assign oe_w  = ctrl.out_en;

  clkout_regs #(.REG_W(REG_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .wrap_i(wrap), .ctrl_o(ctrl), .reload_o(reload)
  );

  clkout_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .run_i(run_w), .cnt_sel_i(sel_w), .tick_i,
    .reload_i(reload), .count_o(count), .wrap_o(wrap)
  );

  clkout_wave u_wave (
    .clk_i, .rst_ni, .wrap_i(wrap), .out_en_i(oe_w), .cnt_sel_i(sel_w),
    .pin_o(clk_pin_o)
  );

  assign ovf_flag_o = ctrl.ovf;
endmodule

// File: rtl/clkout_timer_chk.sv
module clkout_timer_chk #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              run_i,
  input logic              sel_i,
  input logic              oe_i,
  input logic [CNT_W-1:0]  count_i,
  input logic [CNT_W-1:0]  reload_i,
  input logic              wrap_i,
  input logic              pin_i,
  input logic              flag_i
);
  logic clk_mode;
  assign clk_mode = oe_i && !sel_i;

  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !sel_i && tick_i && !(&count_i)) |=> count_i == CNT_W'($past(count_i) + 1'b1)); // R2
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(count_i)); // R2
  AST_WRAP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !sel_i && tick_i && (&count_i)) |=> count_i == $past(reload_i)); // R3
  AST_PIN_ON_WRAP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_mode && $past(clk_mode) && !$stable(pin_i)) |-> $past(wrap_i)); // R4
  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(count_i)); // R5
  AST_SEL_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |=> $stable(count_i)); // R6
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> flag_i); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !(wr_en_i && wr_addr_i == '0)) |=> flag_i); // R8
  AST_ADDR3_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ADDR_W'(3)) |=> ($stable(reload_i) && $stable(run_i) && $stable(sel_i) && $stable(oe_i))); // R9
endmodule

bind clkout_timer clkout_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .run_i(run_w), .sel_i(sel_w), .oe_i(oe_w),
  .count_i(count), .reload_i(reload), .wrap_i(wrap), .pin_i(clk_pin_o),
  .flag_i(ovf_flag_o)
);

// File: tb/sim_clkout_timer.sv
module sim_clkout_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       pin, flag;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  clkout_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .clk_pin_o(pin), .ovf_flag_o(flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver side: called at a negedge, returns at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic push(input int n, input string req);
    exp_q.push_back(n); tag_q.push_back(req);
  endtask

  // wait for a pin edge (rising only if rise_only), end one negedge after the next posedge
  task automatic sync_edge(input bit rise_only);
    logic p;
    p = pin;
    forever begin
      @(negedge clk);
      if (pin != p && (!rise_only || pin)) break;
      p = pin;
    end
    @(posedge clk); @(negedge clk);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 600 && exp_q.size() != 0; i++) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // monitor: measures intervals between pin edges and compares with queued items
  logic last_pin = 1'b1;
  int   last_cyc = 0;
  always @(negedge clk) begin
    if (rst_n && pin != last_pin) begin
      if (exp_q.size() != 0) begin
        int e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        check((cyc - last_cyc) == e, t, cyc - last_cyc, e);
      end
      last_cyc = cyc;
      last_pin = pin;
    end
  end

  initial begin
    int c_w; logic p_hold; bit ok;
    repeat (3) @(negedge clk);
    check(pin == 1'b1, "R1 pin", pin, 1);
    check(flag == 1'b0, "R1 flag", flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(pin == 1'b1 && flag == 1'b0, "R1 after release", {pin, flag}, 2);

    // reload 0xFFF0 -> half period 16
    wr(2'd1, 8'hF0);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h05);
    c_w = cyc;
    repeat (100) @(negedge clk);
    check(pin == 1'b1, "R4 initial level", pin, 1);
    while (pin) @(negedge clk);
    check(cyc - c_w == 65536, "R1 R3 first wrap", cyc - c_w, 65536);
    check(flag == 1'b1, "R8 flag set", flag, 1);

    // R3 R10: steady half periods
    sync_edge(1'b0);
    repeat (4) push(16, "R3 R10 half period");
    drain("R10 drained");

    // R7: reload change mid-interval applies from next wrap
    sync_edge(1'b0);
    push(16, "R7 current interval kept");
    push(32, "R7 new reload");
    push(32, "R7 R10 new reload");
    wr(2'd1, 8'hE0);
    drain("R7 drained");

    // R2: 20 cycles with tick low
    sync_edge(1'b0);
    push(52, "R2 tick gap");
    push(32, "R2 after gap");
    tick = 1'b0;
    repeat (20) @(negedge clk);
    tick = 1'b1;
    drain("R2 drained");

    // R5: stop for 40 cycles, also clears flag (R8)
    sync_edge(1'b0);
    push(72, "R5 paused interval");
    push(32, "R5 after resume");
    repeat (5) @(negedge clk);
    wr(2'd0, 8'h04);
    p_hold = pin;
    repeat (30) @(negedge clk);
    check(pin == p_hold, "R5 pin held", pin, p_hold);
    check(flag == 1'b0, "R8 flag cleared", flag, 0);
    repeat (9) @(negedge clk);
    wr(2'd0, 8'h05);
    drain("R5 drained");
    check(flag == 1'b1, "R8 flag set again", flag, 1);

    // R9: address 3 write ignored
    sync_edge(1'b0);
    push(32, "R9 addr3 ignored");
    push(32, "R9 addr3 ignored");
    wr(2'd3, 8'h00);
    drain("R9 drained");

    // R4: output enable off parks pin high
    wr(2'd0, 8'h01);
    ok = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (!pin) ok = 1'b0;
    end
    check(ok, "R4 pin high when disabled", ok, 1);
    wr(2'd0, 8'h05);

    // R6: select parks pin high and restores level
    sync_edge(1'b0);
    if (pin) sync_edge(1'b0);
    wr(2'd0, 8'h07);
    check(pin == 1'b1, "R6 pin high with select", pin, 1);
    wr(2'd0, 8'h05);
    check(pin == 1'b0, "R6 level restored", pin, 0);

    // R6: select freezes counter (19 + 1 frozen cycles)
    sync_edge(1'b1);
    push(52, "R6 frozen interval");
    push(32, "R6 after select clear");
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h07);
    repeat (19) @(negedge clk);
    wr(2'd0, 8'h05);
    drain("R6 drained");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule